// File: doc/BRIEF.md
# Dual-Width Register ALU

This block is the arithmetic and logic stage of a 64-bit bytecode execution core. It receives one decoded instruction per cycle: an 8-bit opcode, the current destination and source register values, the instruction's 32-bit immediate and, for the wide-load opcode, the immediate of the following frame. One clock later it presents the value to write back into the destination register and a write enable. Division forms with a zero divisor suppress the write and raise a divide-by-zero flag. Opcodes outside its set are dropped without a write.

Each arithmetic opcode has four forms. The opcode's low nibble selects the operand source and the width. The high nibble selects the operation. An immediate operand is sign-extended from 32 bits. Every 32-bit form clears the upper half of the result. Byte-order conversion takes its width from the immediate.

Top module: `xalu_exec`

## Requirements
- R1: The opcode's low nibble selects the form: 0x4 is immediate/32-bit, 0x7 is immediate/64-bit, 0xc is register/32-bit and 0xf is register/64-bit. The high nibble selects the operation: 0 add, 1 sub, 2 mul, 3 unsigned div, 4 or, 5 and, 6 left shift, 7 logical right shift, 8 negate, 9 unsigned remainder, 0xa xor, 0xb move, 0xc arithmetic right shift, 0xe signed div.
- R2: In a 64-bit immediate form, the 32-bit immediate is sign-extended to 64 bits before use. For example, 0xfeeeeee3 becomes 0xfffffffffeeeeee3.
- R3: Every 32-bit form computes on the low 32 bits of its operands and writes a result whose bits 63:32 are zero.
- R4: The shift amount is the low 5 bits of the operand in 32-bit forms and the low 6 bits in 64-bit forms.
- R5: For unsigned div, unsigned remainder and signed div, a divisor of zero in the operation's width gives out_divzero=1, out_wen=0 and out_result=0.
- R6: Signed div treats both operands as two's complement and truncates toward zero. The most negative value divided by -1 returns the most negative value.
- R7: Opcode 0xd4 (little-endian) and opcode 0xdc (big-endian) convert the low 16, 32 or 64 bits of the destination, with the width given by the immediate. Little-endian keeps the low bytes. Big-endian reverses the byte order within the width. Both zero the bits above the width. Any other immediate gives no write.
- R8: Opcode 0x18 writes {in_imm_hi, in_imm}, with in_imm as the low 32 bits.
- R9: The outputs register the inputs of the previous cycle. out_valid equals the previous in_valid. When in_valid was low, out_wen and out_divzero are 0.
- R10: An unsupported opcode gives out_wen=0, out_divzero=0 and out_result=0. Unsupported opcodes are low nibbles other than 4, 7, c and f (except 0x18), high nibble 0xf, negate with low nibble c or f, and conversion with low nibble 7 or f.
- R11: While reset is active, all outputs are 0.
- R12: out_result is 0 whenever out_wen is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_opcode | input | 8 | Opcode byte |
| in_dst | input | XLEN | Destination register value |
| in_src | input | XLEN | Source register value |
| in_imm | input | 32 | Immediate of the instruction frame |
| in_imm_hi | input | 32 | Immediate of the following frame (wide load only) |
| out_valid | output | 1 | Result slot is occupied |
| out_wen | output | 1 | Write out_result to the destination register |
| out_divzero | output | 1 | Division with a zero divisor was suppressed |
| out_result | output | XLEN | Write-back value |

## Verification
Every output is due exactly one rising edge after the cycle in which its instruction is presented; no path through the block takes longer or shorter. The bench therefore places each instruction on the falling edge and holds it for one cycle. It lowers in_valid again and compares all four outputs at the next falling edge, half a period after the capturing edge. This way each comparison sees precisely one instruction's result. An idle cycle is checked in the same way to confirm that nothing is written one edge after in_valid falls.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_MUL  = 4'h2, OP_DIV  = 4'h3,
      OP_OR   = 4'h4, OP_AND  = 4'h5, OP_LSH  = 4'h6, OP_RSH  = 4'h7,
      OP_NEG  = 4'h8, OP_MOD  = 4'h9, OP_XOR  = 4'ha, OP_MOV  = 4'hb,
      OP_ARSH = 4'hc, OP_SWAP = 4'hd, OP_SDIV = 4'he, OP_WIDE = 4'hf
   } alu_op_e;

   typedef struct packed {
      logic    legal;
      alu_op_e op;
      logic    w64;
      logic    use_imm;
      logic    swap_be;
   } alu_ctl_t;

endpackage

// File: rtl/xalu_decode.sv
module xalu_decode
   import xalu_pkg::*;
(
   input  logic [7:0] opcode,
   output alu_ctl_t   ctl
);

   logic [3:0] grp;

   always_comb begin
      grp         = opcode[7:4];
      ctl         = '0;
      ctl.op      = alu_op_e'(grp);
      ctl.use_imm = ~opcode[3];
      ctl.w64     = opcode[0];
      ctl.swap_be = opcode[3];
      // Forms 4/7/c/f: bit 2 set and bits 1:0 equal.
      ctl.legal   = opcode[2] && (opcode[1] == opcode[0]);
      if (grp == 4'hf) ctl.legal = 1'b0;
      if (grp == 4'h8 && opcode[3]) ctl.legal = 1'b0;
      if (grp == 4'hd) begin
         if (opcode[0]) ctl.legal = 1'b0;
         ctl.w64 = 1'b1;
      end
      if (opcode == 8'h18) begin
         ctl.legal   = 1'b1;
         ctl.op      = OP_WIDE;
         ctl.w64     = 1'b1;
         ctl.use_imm = 1'b1;
      end
   end

endmodule

// File: rtl/xalu_div.sv
module xalu_div #(
   parameter int W = 64
) (
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   input  logic         sgn,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);

   logic [W-1:0] n_mag, d_mag, q_mag;
   logic         neg_q;

   always_comb begin
      n_mag = (sgn && num[W-1]) ? -num : num;
      d_mag = (sgn && den[W-1]) ? -den : den;
      neg_q = sgn && (num[W-1] ^ den[W-1]);
      q_mag = (d_mag == '0) ? '0 : n_mag / d_mag;
      quo   = neg_q ? -q_mag : q_mag;
      rem   = (den == '0) ? '0 : num % den;
   end

endmodule

// File: rtl/xalu_bswap.sv
module xalu_bswap #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] val,
   input  logic            be,
   input  logic [31:0]     width_sel,
   output logic [XLEN-1:0] res,
   output logic            ok
);

   localparam int NB = XLEN / 8;

   logic [XLEN-1:0] rev;
   int              w;

   generate
      for (genvar i = 0; i < NB; i++) begin : g_rev
         assign rev[8*i +: 8] = val[XLEN-8-8*i +: 8];
      end
   endgenerate

   always_comb begin
      ok = 1'b1;
      case (width_sel)
         32'd16:  w = 16;
         32'd32:  w = 32;
         32'd64:  w = 64;
         default: begin w = 64; ok = 1'b0; end
      endcase
      if (be) res = rev >> (XLEN - w);
      else    res = val & ~({XLEN{1'b1}} << w);
   end

endmodule

// File: rtl/xalu_exec.sv
module xalu_exec
   import xalu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [7:0]      in_opcode,
   input  logic [XLEN-1:0] in_dst,
   input  logic [XLEN-1:0] in_src,
   input  logic [31:0]     in_imm,
   input  logic [31:0]     in_imm_hi,
   output logic            out_valid,
   output logic            out_wen,
   output logic            out_divzero,
   output logic [XLEN-1:0] out_result
);

   localparam int NW  = 32;
   localparam int SHX = $clog2(XLEN);
   localparam int SHN = $clog2(NW);

   generate
      if (XLEN < 64 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("xalu_exec: XLEN must be a power of two of at least 64");
      end
   endgenerate

   alu_ctl_t        ctl;
   logic [XLEN-1:0] opb, r_w, q_w, m_w, sw_res, res_c;
   logic [NW-1:0]   a_n, b_n, r_n, q_n, m_n;
   logic            sw_ok, is_div, dz, wen_c, w64_q;

   xalu_decode dec_i (.opcode(in_opcode), .ctl(ctl));

   xalu_div #(.W(XLEN)) div_w_i (
      .num(in_dst), .den(opb), .sgn(ctl.op == OP_SDIV), .quo(q_w), .rem(m_w));

   xalu_div #(.W(NW)) div_n_i (
      .num(a_n), .den(b_n), .sgn(ctl.op == OP_SDIV), .quo(q_n), .rem(m_n));

   xalu_bswap #(.XLEN(XLEN)) swap_i (
      .val(in_dst), .be(ctl.swap_be), .width_sel(in_imm), .res(sw_res), .ok(sw_ok));

   always_comb begin
      opb = ctl.use_imm ? {{(XLEN-NW){in_imm[NW-1]}}, in_imm} : in_src;
      a_n = in_dst[NW-1:0];
      b_n = opb[NW-1:0];

      case (ctl.op)
         OP_ADD:  r_w = in_dst + opb;
         OP_SUB:  r_w = in_dst - opb;
         OP_MUL:  r_w = in_dst * opb;
         OP_DIV:  r_w = q_w;
         OP_OR:   r_w = in_dst | opb;
         OP_AND:  r_w = in_dst & opb;
         OP_LSH:  r_w = in_dst << opb[SHX-1:0];
         OP_RSH:  r_w = in_dst >> opb[SHX-1:0];
         OP_NEG:  r_w = -in_dst;
         OP_MOD:  r_w = m_w;
         OP_XOR:  r_w = in_dst ^ opb;
         OP_MOV:  r_w = opb;
         OP_ARSH: r_w = $signed(in_dst) >>> opb[SHX-1:0];
         OP_SDIV: r_w = q_w;
         default: r_w = '0;
      endcase

      case (ctl.op)
         OP_ADD:  r_n = a_n + b_n;
         OP_SUB:  r_n = a_n - b_n;
         OP_MUL:  r_n = a_n * b_n;
         OP_DIV:  r_n = q_n;
         OP_OR:   r_n = a_n | b_n;
         OP_AND:  r_n = a_n & b_n;
         OP_LSH:  r_n = a_n << b_n[SHN-1:0];
         OP_RSH:  r_n = a_n >> b_n[SHN-1:0];
         OP_NEG:  r_n = -a_n;
         OP_MOD:  r_n = m_n;
         OP_XOR:  r_n = a_n ^ b_n;
         OP_MOV:  r_n = b_n;
         OP_ARSH: r_n = $signed(a_n) >>> b_n[SHN-1:0];
         OP_SDIV: r_n = q_n;
         default: r_n = '0;
      endcase

      is_div = (ctl.op == OP_DIV) || (ctl.op == OP_MOD) || (ctl.op == OP_SDIV);
      dz     = is_div && (ctl.w64 ? (opb == '0) : (b_n == '0));
      wen_c  = in_valid && ctl.legal && !dz && ((ctl.op != OP_SWAP) || sw_ok);

      if (ctl.op == OP_WIDE)      res_c = XLEN'({in_imm_hi, in_imm});
      else if (ctl.op == OP_SWAP) res_c = sw_res;
      else if (ctl.w64)           res_c = r_w;
      else                        res_c = {{(XLEN-NW){1'b0}}, r_n};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_wen     <= 1'b0;
         out_divzero <= 1'b0;
         out_result  <= '0;
         w64_q       <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         out_wen     <= wen_c;
         out_divzero <= in_valid && ctl.legal && dz;
         out_result  <= wen_c ? res_c : '0;
         w64_q       <= ctl.w64;
      end
   end

   // R5
   dz_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_divzero |-> !out_wen);

   // R3
   narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_wen && !w64_q) |-> (out_result[XLEN-1:NW] == '0));

   // R9
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R9
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_wen && !out_divzero));

   // R10
   illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.legal |=> (!out_wen && !out_divzero));

   // R12
   quiet_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_wen |-> (out_result == '0));

endmodule

// File: tb/xalu_exec_tb.sv
`timescale 1ns/1ps
module xalu_exec_tb_top;

   localparam real HALF_NS = 2.0;
   localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_opcode = '0;
   logic [63:0] in_dst = '0, in_src = '0;
   logic [31:0] in_imm = '0, in_imm_hi = '0;
   logic        out_valid, out_wen, out_divzero;
   logic [63:0] out_result;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(HALF_NS) clk = ~clk;

   xalu_exec #(.XLEN(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
      .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm), .in_imm_hi(in_imm_hi),
      .out_valid(out_valid), .out_wen(out_wen), .out_divzero(out_divzero),
      .out_result(out_result));

   function automatic logic [63:0] sdiv_ref64(input logic [63:0] a, input logic [63:0] b);
      logic signed [63:0] sa, sb;
      if (a == MIN64 && b == '1) return MIN64;
      sa = a; sb = b;
      return sa / sb;
   endfunction

   function automatic logic [31:0] sdiv_ref32(input logic [31:0] a, input logic [31:0] b);
      logic signed [31:0] sa, sb;
      if (a == 32'h8000_0000 && b == '1) return 32'h8000_0000;
      sa = a; sb = b;
      return sa / sb;
   endfunction

   function automatic string tag_of(input logic [7:0] op);
      if (op == 8'h18) return "R8";
      if (op[7:4] == 4'hd) return "R7";
      if (op[7:4] == 4'he) return "R6";
      if (op[7:4] == 4'h3 || op[7:4] == 4'h9) return "R5";
      if (op[7:4] == 4'h6 || op[7:4] == 4'h7 || op[7:4] == 4'hc) return "R4";
      if (!op[0]) return "R3";
      return "R1";
   endfunction

   task automatic ref_model(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                            input logic [31:0] im, input logic [31:0] imh,
                            output logic wen, output logic dz, output logic [63:0] res);
      logic [63:0] b;
      logic [31:0] d32, b32, r32;
      logic signed [31:0] sd32;
      logic signed [63:0] sd64;
      logic [3:0]  grp;
      int          w;
      wen = 1'b1; dz = 1'b0; res = '0;
      grp = op[7:4];
      b   = op[3] ? s : {{32{im[31]}}, im};
      d32 = d[31:0]; b32 = b[31:0];
      sd32 = d32; sd64 = d;
      if (op == 8'h18) begin res = {imh, im}; return; end
      if (!(op[3:0] == 4'h4 || op[3:0] == 4'h7 || op[3:0] == 4'hc || op[3:0] == 4'hf)
          || grp == 4'hf || (grp == 4'h8 && op[3]) || (grp == 4'hd && op[0])) begin
         wen = 1'b0; return;
      end
      if (grp == 4'hd) begin
         if (im == 16) w = 16; else if (im == 32) w = 32; else if (im == 64) w = 64;
         else begin wen = 1'b0; return; end
         for (int k = 0; k < w / 8; k++)
            res[8*k +: 8] = op[3] ? d[8*(w/8-1-k) +: 8] : d[8*k +: 8];
         return;
      end
      if ((grp == 4'h3 || grp == 4'h9 || grp == 4'he) &&
          (op[0] ? (b == 0) : (b32 == 0))) begin
         wen = 1'b0; dz = 1'b1; return;
      end
      if (op[0]) begin
         case (grp)
            4'h0: res = d + b;
            4'h1: res = d - b;
            4'h2: res = d * b;
            4'h3: res = d / b;
            4'h4: res = d | b;
            4'h5: res = d & b;
            4'h6: res = d << b[5:0];
            4'h7: res = d >> b[5:0];
            4'h8: res = 64'd0 - d;
            4'h9: res = d % b;
            4'ha: res = d ^ b;
            4'hb: res = b;
            4'hc: res = sd64 >>> b[5:0];
            default: res = sdiv_ref64(d, b);
         endcase
      end else begin
         case (grp)
            4'h0: r32 = d32 + b32;
            4'h1: r32 = d32 - b32;
            4'h2: r32 = d32 * b32;
            4'h3: r32 = d32 / b32;
            4'h4: r32 = d32 | b32;
            4'h5: r32 = d32 & b32;
            4'h6: r32 = d32 << b32[4:0];
            4'h7: r32 = d32 >> b32[4:0];
            4'h8: r32 = 32'd0 - d32;
            4'h9: r32 = d32 % b32;
            4'ha: r32 = d32 ^ b32;
            4'hb: r32 = b32;
            4'hc: r32 = sd32 >>> b32[4:0];
            default: r32 = sdiv_ref32(d32, b32);
         endcase
         res = {32'd0, r32};
      end
   endtask

   task automatic run_vec(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                          input logic [31:0] im, input logic [31:0] imh, input string tag);
      logic ew, edz;
      logic [63:0] er;
      @(negedge clk);
      in_opcode = op; in_dst = d; in_src = s; in_imm = im; in_imm_hi = imh; in_valid = 1'b1;
      ref_model(op, d, s, im, imh, ew, edz, er);
      @(negedge clk);
      in_valid = 1'b0;
      n_vec++;
      if (out_valid !== 1'b1 || out_wen !== ew || out_divzero !== edz || out_result !== er) begin
         n_bad++;
         $display("FAIL %s op=%02h: got v=%0b wen=%0b dz=%0b res=%h, expected v=1 wen=%0b dz=%0b res=%h",
                  tag, op, out_valid, out_wen, out_divzero, out_result, ew, edz, er);
      end
   endtask

   function automatic logic [63:0] pick_val();
      case ($urandom % 8)
         0: return 64'd0;
         1: return '1;
         2: return MIN64;
         3: return 64'd1;
         4: return {32'd0, $urandom};
         5: return {{32{1'b1}}, $urandom};
         default: return {$urandom, $urandom};
      endcase
   endfunction

   initial begin
      logic [7:0]  op;
      logic [63:0] d, s;
      logic [31:0] im;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11: outputs are zero while reset is held
      n_vec++;
      if (out_valid !== 1'b0 || out_wen !== 1'b0 || out_divzero !== 1'b0 || out_result !== '0) begin
         n_bad++;
         $display("FAIL R11 reset: got v=%0b wen=%0b dz=%0b res=%h, expected all zero",
                  out_valid, out_wen, out_divzero, out_result);
      end
      rst_n = 1'b1;

      // Directed corner cases
      run_vec(8'h07, 64'd0, 64'd0, 32'hfeeeeee3, 32'd0, "R2");
      run_vec(8'hb7, '1, 64'd0, 32'h8000_0001, 32'd0, "R2");
      run_vec(8'hb4, '1, 64'd0, 32'hffff_fff0, 32'd0, "R3");
      run_vec(8'h0c, 64'hffff_ffff_ffff_ffff, 64'h1, 32'd0, 32'd0, "R3");
      run_vec(8'h6f, 64'h3, 64'd65, 32'd0, 32'd0, "R4");
      run_vec(8'h6c, 64'h3, 64'd33, 32'd0, 32'd0, "R4");
      run_vec(8'hcf, MIN64, 64'd127, 32'd0, 32'd0, "R4");
      run_vec(8'h3f, 64'd10, 64'd0, 32'd0, 32'd0, "R5");
      run_vec(8'h9c, 64'd10, 64'h1_0000_0000, 32'd0, 32'd0, "R5");
      run_vec(8'he4, 64'd10, 64'd0, 32'd0, 32'd0, "R5");
      run_vec(8'hef, MIN64, '1, 32'd0, 32'd0, "R6");
      run_vec(8'hec, 64'h8000_0000, 64'hffff_ffff, 32'd0, 32'd0, "R6");
      run_vec(8'he7, 64'hffff_ffff_ffff_fff9, 64'd0, 32'd2, 32'd0, "R6");
      run_vec(8'hdc, 64'h1122_3344_5566_7788, 64'd0, 32'd16, 32'd0, "R7");
      run_vec(8'hdc, 64'h1122_3344_5566_7788, 64'd0, 32'd64, 32'd0, "R7");
      run_vec(8'hd4, 64'h1122_3344_5566_7788, 64'd0, 32'd32, 32'd0, "R7");
      run_vec(8'hdc, 64'h1122_3344_5566_7788, 64'd0, 32'd8, 32'd0, "R7");
      run_vec(8'h18, 64'd5, 64'd6, 32'hcafe_0001, 32'h8765_4321, "R8");
      run_vec(8'h8c, 64'd5, 64'd6, 32'd1, 32'd0, "R10");
      run_vec(8'hf7, 64'd5, 64'd6, 32'd1, 32'd0, "R10");
      run_vec(8'hd7, 64'd5, 64'd6, 32'd16, 32'd0, "R10");
      run_vec(8'h05, 64'd5, 64'd6, 32'd1, 32'd0, "R10");
      run_vec(8'h2f, 64'h1_0000_0001, 64'h3, 32'd0, 32'd0, "R1");
      run_vec(8'h54, 64'hffff_ffff_ffff_ffff, 64'd0, 32'h8000_00ff, 32'd0, "R1");

      // R9: idle cycle after a legal instruction
      @(negedge clk);
      in_opcode = 8'h07; in_dst = 64'd1; in_imm = 32'd1; in_valid = 1'b0;
      @(negedge clk);
      n_vec++;
      if (out_valid !== 1'b0 || out_wen !== 1'b0 || out_divzero !== 1'b0 || out_result !== '0) begin
         n_bad++;
         $display("FAIL R9 idle: got v=%0b wen=%0b dz=%0b res=%h, expected all zero",
                  out_valid, out_wen, out_divzero, out_result);
      end

      // Constrained random mix
      for (int i = 0; i < 4000; i++) begin
         case ($urandom % 20)
            0:       op = 8'h18;
            1, 2:    op = 8'($urandom);
            default: begin
               op[7:4] = 4'($urandom);
               case ($urandom % 4)
                  0: op[3:0] = 4'h4; 1: op[3:0] = 4'h7; 2: op[3:0] = 4'hc; default: op[3:0] = 4'hf;
               endcase
            end
         endcase
         d = pick_val();
         s = pick_val();
         im = pick_val()[31:0];
         if (op[7:4] == 4'hd) begin
            case ($urandom % 4)
               0: im = 32'd16; 1: im = 32'd32; 2: im = 32'd64; default: im = $urandom % 80;
            endcase
         end else if ((op[7:4] == 4'h6 || op[7:4] == 4'h7 || op[7:4] == 4'hc) && ($urandom % 2 == 1)) begin
            im = $urandom % 64;
         end
         run_vec(op, d, s, im, $urandom, tag_of(op));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(HALF_NS * 2.0 * 150000.0);
      if (!done) begin
         n_bad++;
         $display("FAIL R9 watchdog: got no completion, expected finish within 150000 cycles");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule